// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition Flags

This block is the combinational integer datapath of an 8/16-bit register machine. Each cycle it receives a destination operand, a source operand, a five-bit operation code, a size select and the current carry and half-carry flags. It returns the operation result, the next values of five condition flags and a write enable for each flag. A write enable for the result is also returned, so that compare can update flags without touching the register file.

The block covers binary add and subtract, with and without carry-in. It also covers compare, negate, increment and decrement, add or subtract of the constant 1 or 2 on a full word, and bitwise NOT, AND, OR and XOR. Two decimal-adjust operations repair a byte after a packed-BCD add or subtract. In byte mode only the low byte is computed, and the high byte of the destination passes through unchanged. The surrounding sequencer writes a flag only when that flag's enable is high.

Top module: `alu_bw_core`

## Requirements
- R1: Op 0 (add) gives a+b and op 1 (add with carry) gives a+b+c_in. Both use the selected size. C is the carry out, V is signed overflow, N is the result MSB and Z flags a zero result. All five flags are written. In flg_out and flg_we, bit 4 is H, bit 3 N, bit 2 Z, bit 1 V and bit 0 C.
- R2: For add, subtract, compare and negate, H is the carry or borrow out of bit 3 in byte mode and out of bit 11 in word mode.
- R3: Op 2 (subtract) gives a−b and op 3 (subtract with carry) gives a−b−c_in. C is the borrow out. All five flags are written.
- R4: Op 4 (compare) sets all five flags exactly as op 2 would and drives res_we low.
- R5: Op 11 (negate) gives 0−a in the selected size, with all five flags set as for a subtraction.
- R6: Op 5 (increment) and op 6 (decrement) add or subtract 1 in the selected size. They write N, Z and V and leave H and C unwritten.
- R7: Ops 7, 8, 9 and 10 add 1, add 2, subtract 1 and subtract 2 on the full 16-bit word whatever word_sel is. They write the result and no flag.
- R8: Ops 12 to 15 are NOT a, a AND b, a OR b and a XOR b. They write N and Z, write V as 0, and leave H and C unwritten.
- R9: With word_sel=0, every operation except ops 7 to 10 returns a_in[15:8] unchanged in res_out[15:8]. N and Z then come from the low byte.
- R10: Op 16 adjusts the low byte after a BCD add. It adds 0x06 when the low nibble is above 9 or h_in is 1. It adds 0x60 when the byte is above 0x99 or c_in is 1, and C reports that 0x60 step. N, Z and C are written.
- R11: Op 17 adjusts the low byte after a BCD subtract. It subtracts 0x06 when h_in is 1 and 0x60 when c_in is 1. C keeps c_in, and N, Z and C are written.
- R12: Op codes 18 to 31 write neither the result nor any flag.
- R13: With word_sel=1, arithmetic and logic operations act on all 16 bits, and N is taken from bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | Destination operand |
| b_in | input | 16 | Source operand |
| op_sel | input | 5 | Operation code |
| word_sel | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| c_in | input | 1 | Current carry flag |
| h_in | input | 1 | Current half-carry flag |
| res_out | output | 16 | Operation result |
| res_we | output | 1 | Result is to be written back |
| flg_out | output | 5 | Next flag values {H,N,Z,V,C} |
| flg_we | output | 5 | Per-flag write enables {H,N,Z,V,C} |

## Verification
The block has no state, so any fault in a decode, a carry chain or a size mux appears at the outputs in the same cycle the operands arrive. The bench drives an operation and samples every output half a clock later. Typical faults show up in a few places: a half carry taken from the wrong bit, a borrow with the wrong polarity, or a flag enable raised for an operation that must keep that flag. Each of these changes a masked flag or an enable bit and is caught on the first operand pair that exercises it. The decimal-adjust paths are checked exhaustively against decimal arithmetic over every pair of two-digit BCD values.

// File: rtl/alu_bw_pkg.sv
package alu_bw_pkg;

    localparam int unsigned DATA_W = 16;

    localparam logic [4:0] OP_ADD   = 5'd0;
    localparam logic [4:0] OP_ADC   = 5'd1;
    localparam logic [4:0] OP_SUB   = 5'd2;
    localparam logic [4:0] OP_SBC   = 5'd3;
    localparam logic [4:0] OP_CMP   = 5'd4;
    localparam logic [4:0] OP_INC   = 5'd5;
    localparam logic [4:0] OP_DEC   = 5'd6;
    localparam logic [4:0] OP_KADD1 = 5'd7;
    localparam logic [4:0] OP_KADD2 = 5'd8;
    localparam logic [4:0] OP_KSUB1 = 5'd9;
    localparam logic [4:0] OP_KSUB2 = 5'd10;
    localparam logic [4:0] OP_NEG   = 5'd11;
    localparam logic [4:0] OP_NOT   = 5'd12;
    localparam logic [4:0] OP_AND   = 5'd13;
    localparam logic [4:0] OP_OR    = 5'd14;
    localparam logic [4:0] OP_XOR   = 5'd15;
    localparam logic [4:0] OP_DADD  = 5'd16;
    localparam logic [4:0] OP_DSUB  = 5'd17;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_LOGIC = 2'd1,
        SRC_DECA  = 2'd2,
        SRC_PASS  = 2'd3
    } res_src_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam flags_t WE_ALL  = '{h: 1'b1, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
    localparam flags_t WE_NZV  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
    localparam flags_t WE_NZC  = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b1};
    localparam flags_t WE_NONE = '0;

    typedef struct packed {
        res_src_e src;
        logic     sub;
        logic     use_cin;
        logic     force_word;
        logic     neg_a;
        logic [1:0] kval;
        logic     res_we;
        flags_t   we;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [4:0] op, input logic c_in);
        ctl_t k;
        k = '{src: SRC_ARITH, sub: 1'b0, use_cin: 1'b0, force_word: 1'b0,
              neg_a: 1'b0, kval: 2'd0, res_we: 1'b1, we: WE_ALL};
        case (op)
            OP_ADD:   ;
            OP_ADC:   k.use_cin = c_in;
            OP_SUB:   k.sub = 1'b1;
            OP_SBC:   begin k.sub = 1'b1; k.use_cin = c_in; end
            OP_CMP:   begin k.sub = 1'b1; k.res_we = 1'b0; end
            OP_INC:   begin k.kval = 2'd1; k.we = WE_NZV; end
            OP_DEC:   begin k.kval = 2'd1; k.sub = 1'b1; k.we = WE_NZV; end
            OP_KADD1: begin k.kval = 2'd1; k.force_word = 1'b1; k.we = WE_NONE; end
            OP_KADD2: begin k.kval = 2'd2; k.force_word = 1'b1; k.we = WE_NONE; end
            OP_KSUB1: begin k.kval = 2'd1; k.sub = 1'b1; k.force_word = 1'b1; k.we = WE_NONE; end
            OP_KSUB2: begin k.kval = 2'd2; k.sub = 1'b1; k.force_word = 1'b1; k.we = WE_NONE; end
            OP_NEG:   begin k.sub = 1'b1; k.neg_a = 1'b1; end
            OP_NOT, OP_AND, OP_OR, OP_XOR: begin k.src = SRC_LOGIC; k.we = WE_NZV; end
            OP_DADD, OP_DSUB: begin k.src = SRC_DECA; k.we = WE_NZC; end
            default:  begin k.src = SRC_PASS; k.res_we = 1'b0; k.we = WE_NONE; end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/alu_bw_addsub.sv
module alu_bw_addsub #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          sub,
    input  logic          cin,
    input  logic          word,
    output logic [DW-1:0] sum,
    output logic          hc,
    output logic          vc,
    output logic          cc
);
    localparam int unsigned BW = DW / 2;
    localparam int unsigned HW = DW - 4;
    localparam int unsigned NB = BW - 4;

    logic [DW-1:0] bx;
    logic          ci;
    logic [DW:0]   wsum;
    logic [BW:0]   bsum;
    logic [HW:0]   whalf;
    logic [NB:0]   bhalf;
    logic          carry, half, sa, sb, sr;

    always_comb begin
        bx    = sub ? ~opb : opb;
        ci    = sub ^ cin;
        wsum  = {1'b0, opa} + {1'b0, bx} + {{DW{1'b0}}, ci};
        bsum  = {1'b0, opa[BW-1:0]} + {1'b0, bx[BW-1:0]} + {{BW{1'b0}}, ci};
        whalf = {1'b0, opa[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, ci};
        bhalf = {1'b0, opa[NB-1:0]} + {1'b0, bx[NB-1:0]} + {{NB{1'b0}}, ci};
        if (word) begin
            sum   = wsum[DW-1:0];
            carry = wsum[DW];
            half  = whalf[HW];
            sa    = opa[DW-1];
            sb    = bx[DW-1];
            sr    = wsum[DW-1];
        end else begin
            sum   = {opa[DW-1:BW], bsum[BW-1:0]};
            carry = bsum[BW];
            half  = bhalf[NB];
            sa    = opa[BW-1];
            sb    = bx[BW-1];
            sr    = bsum[BW-1];
        end
        cc = sub ? ~carry : carry;
        hc = sub ? ~half : half;
        vc = (sa == sb) && (sr != sa);
    end

    always_comb begin
        if (sub && word && !cin && (opa == opb)) begin
            p_self_sub_zero_r3: assert (sum == '0 && !cc && !vc)
                else $error("self subtraction not zero");
        end
    end

endmodule

// File: rtl/alu_bw_logic.sv
module alu_bw_logic #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [1:0]    fn,
    input  logic          word,
    output logic [DW-1:0] res
);
    localparam int unsigned BW = DW / 2;

    logic [DW-1:0] full;

    always_comb begin
        unique case (fn)
            2'd0: full = ~opa;
            2'd1: full = opa & opb;
            2'd2: full = opa | opb;
            default: full = opa ^ opb;
        endcase
    end

    generate
        if (DW > BW) begin : g_size
            assign res = word ? full : {opa[DW-1:BW], full[BW-1:0]};
        end
    endgenerate

endmodule

// File: rtl/alu_bw_decadj.sv
module alu_bw_decadj #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic          sub,
    input  logic          hin,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    localparam int unsigned BW = DW / 2;

    logic [BW-1:0] lo_byte, corr, adj;
    logic          fix_lo, fix_hi;

    always_comb begin
        lo_byte = opa[BW-1:0];
        if (sub) begin
            fix_lo = hin;
            fix_hi = cin;
        end else begin
            fix_lo = hin || (lo_byte[3:0] > 4'd9);
            fix_hi = cin || (lo_byte > 8'h99);
        end
        corr = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
        adj  = sub ? (lo_byte - corr) : (lo_byte + corr);
        res  = {opa[DW-1:BW], adj};
        cout = sub ? cin : fix_hi;
    end

    always_comb begin
        if (!sub && !hin && !cin && lo_byte[3:0] <= 4'd9 && lo_byte <= 8'h99) begin
            p_dadd_identity_r10: assert (adj == lo_byte && !cout)
                else $error("decimal adjust altered a valid byte");
        end
    end

endmodule

// File: rtl/alu_bw_core.sv
module alu_bw_core
    import alu_bw_pkg::*;
(
    input  logic [15:0] a_in,
    input  logic [15:0] b_in,
    input  logic [4:0]  op_sel,
    input  logic        word_sel,
    input  logic        c_in,
    input  logic        h_in,
    output logic [15:0] res_out,
    output logic        res_we,
    output logic [4:0]  flg_out,
    output logic [4:0]  flg_we
);
    localparam int unsigned DW = DATA_W;
    localparam int unsigned BW = DW / 2;

    ctl_t          ctl;
    logic [DW-1:0] as_a, as_b, as_sum, lg_res, dj_res;
    logic          as_word, as_h, as_v, as_c, dj_c;
    logic          nz_word;
    flags_t        nxt;

    always_comb begin
        ctl     = decode_op(op_sel, c_in);
        as_word = word_sel | ctl.force_word;
        if (ctl.neg_a) begin
            as_a = word_sel ? '0 : {a_in[DW-1:BW], {BW{1'b0}}};
            as_b = a_in;
        end else if (ctl.kval != 2'd0) begin
            as_a = a_in;
            as_b = {{(DW-2){1'b0}}, ctl.kval};
        end else begin
            as_a = a_in;
            as_b = b_in;
        end
    end

    alu_bw_addsub #(.DW(DW)) u_addsub (
        .opa(as_a), .opb(as_b), .sub(ctl.sub), .cin(ctl.use_cin), .word(as_word),
        .sum(as_sum), .hc(as_h), .vc(as_v), .cc(as_c)
    );

    alu_bw_logic #(.DW(DW)) u_logic (
        .opa(a_in), .opb(b_in), .fn(op_sel[1:0]), .word(word_sel), .res(lg_res)
    );

    alu_bw_decadj #(.DW(DW)) u_decadj (
        .opa(a_in), .sub(op_sel[0]), .hin(h_in), .cin(c_in), .res(dj_res), .cout(dj_c)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_ARITH: res_out = as_sum;
            SRC_LOGIC: res_out = lg_res;
            SRC_DECA:  res_out = dj_res;
            default:   res_out = a_in;
        endcase
        nz_word = as_word && (ctl.src != SRC_DECA);
        nxt.h = as_h;
        nxt.n = nz_word ? res_out[DW-1] : res_out[BW-1];
        nxt.z = nz_word ? (res_out == '0) : (res_out[BW-1:0] == '0);
        nxt.v = (ctl.src == SRC_LOGIC) ? 1'b0 : as_v;
        nxt.c = (ctl.src == SRC_DECA) ? dj_c : as_c;
        flg_out = nxt;
        flg_we  = ctl.we;
        res_we  = ctl.res_we;
    end

    always_comb begin
        if (op_sel >= OP_KADD1 && op_sel <= OP_KSUB2) begin
            p_const_no_flags_r7: assert (flg_we == 5'b0 && res_we)
                else $error("constant step touched flags");
        end
        if (op_sel == OP_CMP) begin
            p_cmp_no_write_r4: assert (!res_we && flg_we == 5'b11111)
                else $error("compare wrote result");
        end
        if (op_sel >= OP_NOT && op_sel <= OP_XOR) begin
            p_logic_v_clear_r8: assert (!flg_out[1] && flg_we[1] && !flg_we[4] && !flg_we[0])
                else $error("logic op flag handling");
        end
        if (!word_sel && res_we && !(op_sel >= OP_KADD1 && op_sel <= OP_KSUB2)) begin
            p_byte_upper_keep_r9: assert (res_out[DW-1:BW] == a_in[DW-1:BW])
                else $error("byte op changed upper byte");
        end
        if (op_sel > OP_DSUB) begin
            p_unused_code_idle_r12: assert (!res_we && flg_we == 5'b0)
                else $error("reserved code wrote state");
        end
    end

endmodule

// File: tb/alu_bw_core_tb.sv
module alu_bw_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [4:0]  op_sel = '0;
    logic        word_sel = 1'b0, c_in = 1'b0, h_in = 1'b0;
    logic [15:0] res_out;
    logic        res_we;
    logic [4:0]  flg_out, flg_we;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    alu_bw_core u_dut (
        .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .word_sel(word_sel),
        .c_in(c_in), .h_in(h_in), .res_out(res_out), .res_we(res_we),
        .flg_out(flg_out), .flg_we(flg_we)
    );

    typedef struct packed {
        logic [15:0] r;
        logic [4:0]  f;
        logic [4:0]  we;
        logic        rwe;
    } exp_t;

    function automatic exp_t model(input logic [4:0] op, input logic [15:0] a, b,
                                   input logic w, c);
        exp_t e;
        int wd, hb, mask, hm, av, bv, ci, full, r;
        logic sub, useas, fh, fv, fc, sa, sb, sr;
        e = '0; e.r = a; e.rwe = 1'b1;
        wd = w ? 16 : 8;
        if (op >= 7 && op <= 10) wd = 16;
        hb = wd - 4; mask = (1 << wd) - 1; hm = (1 << hb) - 1;
        av = int'(a) & mask; bv = int'(b) & mask; ci = 0;
        sub = 1'b0; useas = 1'b1; fh = 1'b0; fv = 1'b0; fc = 1'b0; r = 0;
        case (op)
            0: ;
            1: ci = int'(c);
            2, 4: sub = 1'b1;
            3: begin sub = 1'b1; ci = int'(c); end
            5, 7: bv = 1;
            6, 9: begin bv = 1; sub = 1'b1; end
            8: bv = 2;
            10: begin bv = 2; sub = 1'b1; end
            11: begin bv = av; av = 0; sub = 1'b1; end
            default: useas = 1'b0;
        endcase
        if (useas) begin
            if (!sub) begin
                full = av + bv + ci;
                fc = ((full >> wd) & 1) != 0;
                fh = ((((av & hm) + (bv & hm) + ci) >> hb) & 1) != 0;
            end else begin
                full = av - bv - ci;
                fc = av < (bv + ci);
                fh = (av & hm) < ((bv & hm) + ci);
            end
            r = full & mask;
            sa = ((av >> (wd-1)) & 1) != 0;
            sb = ((bv >> (wd-1)) & 1) != 0;
            sr = ((r >> (wd-1)) & 1) != 0;
            fv = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
        end else begin
            case (op)
                12: r = (~av) & mask;
                13: r = av & bv;
                14: r = av | bv;
                15: r = av ^ bv;
                default: begin e.rwe = 1'b0; return e; end
            endcase
        end
        e.r = (wd == 16) ? 16'(r) : {a[15:8], 8'(r)};
        e.f = {fh, (((r >> (wd-1)) & 1) != 0), (r == 0), fv, fc};
        if (op <= 4 || op == 11) e.we = 5'b11111;
        else if (op <= 6 || op >= 12) e.we = 5'b01110;
        else e.we = 5'b00000;
        e.rwe = (op != 4);
        return e;
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        if (op <= 1) return "R1";
        if (op <= 3) return "R3";
        if (op == 4) return "R4";
        if (op <= 6) return "R6";
        if (op <= 10) return "R7";
        if (op == 11) return "R5";
        if (op <= 15) return "R8";
        return "R12";
    endfunction

    task automatic drive(input logic [4:0] op, input logic [15:0] a, b,
                         input logic w, c, h);
        @(posedge clk);
        op_sel = op; a_in = a; b_in = b; word_sel = w; c_in = c; h_in = h;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input exp_t e);
        logic bad;
        bad = 1'b0;
        if (res_we !== e.rwe) bad = 1'b1;
        if (e.rwe && res_out !== e.r) bad = 1'b1;
        if (flg_we !== e.we) bad = 1'b1;
        if (((flg_out ^ e.f) & e.we) !== 5'b0) bad = 1'b1;
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h b=%h w=%b c=%b h=%b: actual res=%h rwe=%b f=%b fwe=%b expected res=%h rwe=%b f=%b fwe=%b",
                     tag, op_sel, a_in, b_in, word_sel, c_in, h_in,
                     res_out, res_we, flg_out, flg_we, e.r, e.rwe, e.f, e.we);
        end
    endtask

    task automatic run(input string tag, input logic [4:0] op, input logic [15:0] a, b,
                       input logic w, c, h);
        drive(op, a, b, w, c, h);
        check(tag, model(op, a, b, w, c));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t e;
        logic [4:0] op;
        logic [8:0] s;
        logic [7:0] xb, yb, d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: all inputs zero is an 8-bit add of zeros (R1)
        check("R1", model(5'd0, 16'h0, 16'h0, 1'b0, 1'b0));

        run("R2", 5'd0, 16'h000F, 16'h0001, 1'b0, 1'b0, 1'b0);
        run("R2", 5'd0, 16'h0FFF, 16'h0001, 1'b1, 1'b0, 1'b0);
        run("R2", 5'd2, 16'h1000, 16'h0001, 1'b1, 1'b0, 1'b0);
        run("R2", 5'd4, 16'h0010, 16'h0001, 1'b0, 1'b0, 1'b0);
        run("R13", 5'd0, 16'h7FFF, 16'h0001, 1'b1, 1'b0, 1'b0);
        run("R13", 5'd13, 16'hF0F0, 16'h8F00, 1'b1, 1'b0, 1'b0);
        run("R9", 5'd0, 16'hA5FF, 16'h3301, 1'b0, 1'b0, 1'b0);
        run("R9", 5'd12, 16'h5A00, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        run("R1", 5'd1, 16'h00FF, 16'h0000, 1'b0, 1'b1, 1'b0);
        run("R3", 5'd3, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0);
        run("R4", 5'd4, 16'h1234, 16'h1234, 1'b1, 1'b0, 1'b0);
        run("R5", 5'd11, 16'h1280, 16'h0000, 1'b0, 1'b0, 1'b0);
        run("R5", 5'd11, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0);
        run("R6", 5'd5, 16'h007F, 16'h0000, 1'b0, 1'b1, 1'b1);
        run("R6", 5'd6, 16'h8000, 16'h0000, 1'b1, 1'b0, 1'b0);
        run("R7", 5'd8, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0);
        run("R7", 5'd10, 16'h0001, 16'h0000, 1'b0, 1'b1, 1'b1);
        run("R12", 5'd20, 16'hBEEF, 16'h1111, 1'b1, 1'b1, 1'b1);
        run("R12", 5'd31, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            op = 5'($urandom_range(0, 31));
            if (op == 5'd16 || op == 5'd17) op = 5'd0;
            run(tag_of(op), op, 16'($urandom), 16'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
        end

        // exhaustive packed-BCD pairs against decimal arithmetic (R10, R11)
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                xb = to_bcd(x); yb = to_bcd(y);
                s = {1'b0, xb} + {1'b0, yb};
                drive(5'd16, {8'h00, s[7:0]}, 16'h0, 1'b1, s[8],
                      (xb[3:0] + yb[3:0]) > 5'd15);
                e = '0; e.rwe = 1'b1; e.we = 5'b01101;
                e.r = {8'h00, to_bcd((x + y) % 100)};
                e.f = {1'b0, e.r[7], ((x + y) % 100) == 0, 1'b0, (x + y) >= 100};
                check("R10", e);

                d = xb - yb;
                drive(5'd17, {8'h00, d}, 16'h0, 1'b0, xb < yb, xb[3:0] < yb[3:0]);
                e = '0; e.rwe = 1'b1; e.we = 5'b01101;
                e.r = {8'h00, to_bcd((x - y + 100) % 100)};
                e.f = {1'b0, e.r[7], x == y, 1'b0, x < y};
                check("R11", e);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule